// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Classification

This block is the serial side of a single-channel voice codec. It sends and receives one 13-bit linear sample per frame over a bit clock and an 8 kHz frame sync. The bit clock, the sync and the serial input are sampled on the system clock `clk`. An edge detector in the top module turns the bit clock into one-cycle rise and fall events. Each sync pulse is measured in bit-clock falling edges, and the result becomes the framing mode for the next frame. A pulse seen high on one falling edge gives short framing. A pulse seen high on two or more falling edges gives long framing.

The transmit side captures `tx_sample` when a frame starts and shifts it out MSB first on bit-clock rising edges. It drives `tx_oe`, which the pad uses for tri-state control. The receive side gathers 13 bits from `rx_data` on bit-clock falling edges and presents the word with a one-cycle strobe. While `pdown_in` is high the transmit output is released. After power-down ends, the first two frames stay silent.

The sync classifier has three states. `SY_LOW` goes to `SY_ONE` when sync is high on a falling edge, and this is the frame start. `SY_ONE` goes to `SY_MULTI` when sync is still high, or back to `SY_LOW` when it is low, which classifies the pulse as short. `SY_MULTI` goes to `SY_LOW` when sync is low, which classifies it as long. The transmitter has four states. `TX_OFF` goes to `TX_ARMED` at frame start. `TX_ARMED` goes to `TX_SHIFT` on the next rise, which launches the MSB. `TX_SHIFT` goes to `TX_OFF` at the half-LSB fall, or to `TX_HOLD` in long framing while sync is still high. `TX_HOLD` goes to `TX_OFF` when sync drops. Power-down sends the transmitter to `TX_OFF` from any state. The receiver has two states. `RX_IDLE` goes to `RX_RUN` at frame start, and `RX_RUN` goes back to `RX_IDLE` after the 13th sample.

Top module: `pcm_serial_port`

## Requirements
- R1: A sync pulse sampled high on two or more consecutive bit-clock falling edges is classified as long. `long_sync` becomes 1 on the first falling edge that samples sync low, and it changes only on bit-clock falling edges.
- R2: A sync pulse sampled high on exactly one falling edge is classified as short. `long_sync` becomes 0 on the next falling edge.
- R3: A frame uses the mode that was classified from the previous sync pulse. After reset, before any pulse has been classified, frames use short mode.
- R4: A frame starts on the falling edge on which sync is first seen high. On the next bit-clock rising edge, `tx_oe` asserts and `tx_data` carries bit 12 (the MSB). Each later rising edge presents the next lower bit.
- R5: In short mode, `tx_oe` deasserts on the bit-clock falling edge inside the 13th bit period. That is 12.5 bit periods after the MSB launch.
- R6: In long mode, `tx_oe` stays high until the later of two events: the half-LSB falling edge, and the first clock on which sync is seen low.
- R7: The receiver samples `rx_data` on the 13 falling edges that follow the frame-start falling edge. The first sample is placed at bit 12. On the 13th sample, `rx_valid` pulses for one clock with the full word on `rx_word`.
- R8: Bit periods after the 13th in a frame are ignored. `tx_oe` stays low and there is no second `rx_valid` until the next frame start.
- R9: While `pdown_in` is high, `tx_oe` is low from the next clock on. After `pdown_in` falls, the next two frames keep `tx_oe` low, and the third frame transmits.
- R10: After reset, `tx_oe`, `rx_valid` and `long_sync` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all port inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock |
| fsync_in | input | 1 | Frame sync, one rising edge per frame |
| pdown_in | input | 1 | Power-down; releases the transmit output |
| tx_sample | input | 13 | Parallel sample to transmit, captured at frame start |
| rx_data | input | 1 | Serial receive data |
| tx_data | output | 1 | Serial transmit data, valid while `tx_oe` is high |
| tx_oe | output | 1 | Transmit output enable (1 drives the pad) |
| rx_word | output | 13 | Last received word |
| rx_valid | output | 1 | One-clock strobe when `rx_word` is updated |
| long_sync | output | 1 | Framing mode for the next frame (1 long, 0 short) |

## Verification
Every output is one register stage after the `clk` edge that sees the bit-clock or sync event causing it. `tx_oe` and `tx_data` change right after the edge that sees the rise or the half-LSB fall. `rx_valid` is high for the single clock after the edge that sees the 13th sampling fall. `long_sync` updates after the edge that first sees sync low on a fall. The bench drives all inputs on the falling edge of `clk`. It advances a behavioural model on every rising edge and compares all outputs at the next falling edge, so each result is checked in the clock it is due. Per-frame checks count `tx_oe` high cycles against the expected 100 or 120 clocks (8 clocks per bit), and check the received word, the single strobe and the mode flag.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        SY_LOW   = 2'd0,
        SY_ONE   = 2'd1,
        SY_MULTI = 2'd2
    } sync_state_e;

    typedef enum logic [1:0] {
        TX_OFF    = 2'd0,
        TX_ARMED  = 2'd1,
        TX_SHIFT  = 2'd2,
        TX_HOLD   = 2'd3
    } tx_state_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RUN  = 1'b1
    } rx_state_e;

endpackage

// File: rtl/pcm_sync_classifier.sv
module pcm_sync_classifier
    import pcm_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_fall,
    input  logic fsync,
    output logic frame_start,
    output logic long_mode
);

    sync_state_e state_q, state_nx;
    logic        long_nx;

    // frame begins on the first fall that sees sync high
    assign frame_start = bit_fall && fsync && (state_q == SY_LOW);

    always_comb begin
        state_nx = state_q;
        long_nx  = long_mode;
        if (bit_fall) begin
            unique case (state_q)
                SY_LOW: begin
                    if (fsync) state_nx = SY_ONE;
                end
                SY_ONE: begin
                    if (fsync) begin
                        state_nx = SY_MULTI;
                    end else begin
                        state_nx = SY_LOW;
                        long_nx  = 1'b0;
                    end
                end
                SY_MULTI: begin
                    if (!fsync) begin
                        state_nx = SY_LOW;
                        long_nx  = 1'b1;
                    end
                end
                default: state_nx = SY_LOW;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SY_LOW;
            long_mode <= 1'b0;
        end else begin
            state_q   <= state_nx;
            long_mode <= long_nx;
        end
    end

    AST_MODE_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(long_mode) |-> $past(bit_fall)); // R1

endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
    import pcm_port_pkg::*;
#(
    parameter int WORD_W       = 13,
    parameter int BLANK_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              bit_fall,
    input  logic              frame_start,
    input  logic              frame_long,
    input  logic              fsync,
    input  logic              pdown,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_bit,
    output logic              tx_oe
);

    localparam int IDX_W   = $clog2(WORD_W);
    localparam int BLANK_W = $clog2(BLANK_FRAMES + 1);
    localparam logic [IDX_W-1:0]   LAST_IDX  = IDX_W'(WORD_W - 1);
    localparam logic [BLANK_W-1:0] BLANK_MAX = BLANK_W'(BLANK_FRAMES);

    tx_state_e           state_q, state_nx;
    logic [WORD_W-1:0]   shreg_q, shreg_nx;
    logic [IDX_W-1:0]    idx_q, idx_nx;
    logic [BLANK_W-1:0]  blank_q, blank_nx;
    logic                bit_q, bit_nx;
    logic                oe_q, oe_nx;
    logic                long_q, long_nx;
    logic                mute_q, mute_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_OFF;
            shreg_q <= '0;
            idx_q   <= '0;
            blank_q <= '0;
            bit_q   <= 1'b0;
            oe_q    <= 1'b0;
            long_q  <= 1'b0;
            mute_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            shreg_q <= shreg_nx;
            idx_q   <= idx_nx;
            blank_q <= blank_nx;
            bit_q   <= bit_nx;
            oe_q    <= oe_nx;
            long_q  <= long_nx;
            mute_q  <= mute_nx;
        end
    end

    // transitions and output values
    always_comb begin
        state_nx = state_q;
        shreg_nx = shreg_q;
        idx_nx   = idx_q;
        blank_nx = blank_q;
        bit_nx   = bit_q;
        oe_nx    = oe_q;
        long_nx  = long_q;
        mute_nx  = mute_q;
        if (pdown) begin
            state_nx = TX_OFF;
            oe_nx    = 1'b0;
            blank_nx = BLANK_MAX;
        end else begin
            unique case (state_q)
                TX_OFF: begin
                end
                TX_ARMED: begin
                    if (bit_rise) begin
                        state_nx = TX_SHIFT;
                        idx_nx   = '0;
                        bit_nx   = shreg_q[WORD_W-1];
                        shreg_nx = shreg_q << 1;
                        oe_nx    = !mute_q;
                    end
                end
                TX_SHIFT: begin
                    if (bit_rise && (idx_q < LAST_IDX)) begin
                        idx_nx   = idx_q + IDX_W'(1);
                        bit_nx   = shreg_q[WORD_W-1];
                        shreg_nx = shreg_q << 1;
                    end else if (bit_fall && (idx_q == LAST_IDX)) begin
                        if (!long_q || !fsync) begin
                            state_nx = TX_OFF;
                            oe_nx    = 1'b0;
                        end else begin
                            state_nx = TX_HOLD;
                        end
                    end
                end
                TX_HOLD: begin
                    if (!fsync) begin
                        state_nx = TX_OFF;
                        oe_nx    = 1'b0;
                    end
                end
                default: state_nx = TX_OFF;
            endcase
            if (frame_start) begin
                state_nx = TX_ARMED;
                oe_nx    = 1'b0;
                shreg_nx = tx_word;
                long_nx  = frame_long;
                mute_nx  = (blank_q != '0);
                if (blank_q != '0) blank_nx = blank_q - BLANK_W'(1);
            end
        end
    end

    assign tx_oe  = oe_q;
    assign tx_bit = bit_q & oe_q;

    AST_PDOWN_RELEASES_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        pdown |=> !tx_oe); // R9
    AST_OE_RISES_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(bit_rise)); // R4
    AST_SHORT_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_q) && !$past(pdown) && !$past(long_q) |-> $past(bit_fall)); // R5
    AST_LONG_HELD_WHILE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q && long_q && fsync && !pdown && !frame_start |=> oe_q); // R6

endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_fall,
    input  logic              frame_start,
    input  logic              rx_bit,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

    rx_state_e         state_q, state_nx;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;
    logic [WORD_W-1:0] acc_q, acc_nx;
    logic [WORD_W-1:0] word_nx;
    logic              valid_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RX_IDLE;
            cnt_q    <= '0;
            acc_q    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            state_q  <= state_nx;
            cnt_q    <= cnt_nx;
            acc_q    <= acc_nx;
            rx_word  <= word_nx;
            rx_valid <= valid_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        acc_nx   = acc_q;
        word_nx  = rx_word;
        valid_nx = 1'b0;
        if (frame_start) begin
            state_nx = RX_RUN;
            cnt_nx   = '0;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                end
                RX_RUN: begin
                    if (bit_fall) begin
                        acc_nx = {acc_q[WORD_W-2:0], rx_bit};
                        if (cnt_q == LAST_CNT) begin
                            state_nx = RX_IDLE;
                            word_nx  = {acc_q[WORD_W-2:0], rx_bit};
                            valid_nx = 1'b1;
                        end else begin
                            cnt_nx = cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: state_nx = RX_IDLE;
            endcase
        end
    end

    AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7
    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bit_fall)); // R7

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
    parameter int WORD_W       = 13,
    parameter int BLANK_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_in,
    input  logic              fsync_in,
    input  logic              pdown_in,
    input  logic [WORD_W-1:0] tx_sample,
    input  logic              rx_data,
    output logic              tx_data,
    output logic              tx_oe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              long_sync
);

    logic bclk_q;
    logic bit_rise;
    logic bit_fall;
    logic frame_start;

    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk_in;
    end

    assign bit_rise = !bclk_q && bclk_in;
    assign bit_fall = bclk_q && !bclk_in;

    pcm_sync_classifier u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_fall    (bit_fall),
        .fsync       (fsync_in),
        .frame_start (frame_start),
        .long_mode   (long_sync)
    );

    pcm_tx_serializer #(
        .WORD_W       (WORD_W),
        .BLANK_FRAMES (BLANK_FRAMES)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_rise    (bit_rise),
        .bit_fall    (bit_fall),
        .frame_start (frame_start),
        .frame_long  (long_sync),
        .fsync       (fsync_in),
        .pdown       (pdown_in),
        .tx_word     (tx_sample),
        .tx_bit      (tx_data),
        .tx_oe       (tx_oe)
    );

    pcm_rx_deserializer #(
        .WORD_W (WORD_W)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_fall    (bit_fall),
        .frame_start (frame_start),
        .rx_bit      (rx_data),
        .rx_word     (rx_word),
        .rx_valid    (rx_valid)
    );

    AST_NO_DRIVE_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_data); // R4

endmodule

// File: tb/sim_pcm_serial_port.sv
`timescale 1ns/1ps
module sim_pcm_serial_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_in = 1'b0;
    logic        fsync_in = 1'b0;
    logic        pdown_in = 1'b0;
    logic [12:0] tx_sample = '0;
    logic        rx_data = 1'b0;
    logic        tx_data, tx_oe, rx_valid, long_sync;
    logic [12:0] rx_word;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pcm_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fsync_in(fsync_in),
        .pdown_in(pdown_in), .tx_sample(tx_sample), .rx_data(rx_data),
        .tx_data(tx_data), .tx_oe(tx_oe), .rx_word(rx_word),
        .rx_valid(rx_valid), .long_sync(long_sync)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // behavioural reference model
    int m_prev, m_cnt, m_long, m_state, m_pos, m_oe, m_bit, m_curlong, m_mute, m_blank;
    int m_rxact, m_rxcnt, m_valid;
    logic [12:0] m_word, m_rxacc, m_rxword;
    bit model_on = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_prev = 0; m_cnt = 0; m_long = 0; m_state = 0; m_pos = 0; m_oe = 0;
            m_bit = 0; m_curlong = 0; m_mute = 0; m_blank = 0; m_rxact = 0;
            m_rxcnt = 0; m_valid = 0; m_word = '0; m_rxacc = '0; m_rxword = '0;
        end else begin
            bit rise, fall, start;
            rise = (m_prev == 0) && bclk_in;
            fall = (m_prev == 1) && !bclk_in;
            m_prev = bclk_in;
            start = fall && fsync_in && (m_cnt == 0);
            m_valid = 0;
            if (fall && m_rxact == 1 && !start) begin
                m_rxacc = {m_rxacc[11:0], rx_data};
                m_rxcnt++;
                if (m_rxcnt == 13) begin
                    m_valid = 1; m_rxword = m_rxacc; m_rxact = 0;
                end
            end
            if (start) begin m_rxact = 1; m_rxcnt = 0; end
            if (pdown_in) begin
                m_state = 0; m_oe = 0; m_blank = 2;
            end else begin
                if (m_state == 1 && rise) begin
                    m_state = 2; m_pos = 0; m_bit = m_word[12]; m_oe = !m_mute;
                end else if (m_state == 2 && rise && m_pos < 12) begin
                    m_pos++; m_bit = m_word[12 - m_pos];
                end else if (m_state == 2 && fall && m_pos == 12) begin
                    if (!m_curlong || !fsync_in) begin m_state = 0; m_oe = 0; end
                    else m_state = 3;
                end else if (m_state == 3 && !fsync_in) begin
                    m_state = 0; m_oe = 0;
                end
                if (start) begin
                    m_state = 1; m_oe = 0; m_word = tx_sample; m_curlong = m_long;
                    m_mute = (m_blank > 0);
                    if (m_blank > 0) m_blank--;
                end
            end
            if (fall) begin
                if (fsync_in) m_cnt++;
                else begin
                    if (m_cnt == 1) m_long = 0;
                    else if (m_cnt >= 2) m_long = 1;
                    m_cnt = 0;
                end
            end
        end
    end

    // per-frame monitors
    int oe_cyc, valid_cnt, first_bit;
    logic prev_oe = 1'b0;
    logic [12:0] got_word;

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check(tx_oe == m_oe[0], "R4 R5 R6 R9 tx_oe vs model", tx_oe, m_oe);
            if (m_oe != 0)
                check(tx_data == m_bit[0], "R4 tx_data vs model", tx_data, m_bit);
            check(rx_valid == m_valid[0], "R7 R8 rx_valid vs model", rx_valid, m_valid);
            if (m_valid != 0)
                check(rx_word == m_rxword, "R7 rx_word vs model", rx_word, m_rxword);
            check(long_sync == m_long[0], "R1 R2 long_sync vs model", long_sync, m_long);
            if (tx_oe) oe_cyc++;
            if (tx_oe && !prev_oe) first_bit = tx_data;
            if (rx_valid) begin valid_cnt++; got_word = rx_word; end
            prev_oe = tx_oe;
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    int exp_long = 0;
    int muted_left = 0;

    // one frame of 20 bit periods, 8 clocks each
    task automatic run_frame(input int sync_bits, input logic [12:0] txw,
                             input logic [12:0] rxw, input int pd_from, input int pd_to);
        int used_long, muted, exp_oe;
        bit had_pd;
        used_long = exp_long;
        muted = (muted_left > 0);
        if (muted_left > 0) muted_left--;
        had_pd = (pd_from >= 0);
        oe_cyc = 0; valid_cnt = 0; first_bit = -1;
        for (int p = 0; p < 20; p++) begin
            @(negedge clk);
            bclk_in = 1'b1;
            fsync_in = (p < sync_bits);
            if (p == 0) tx_sample = txw;
            rx_data = (p >= 1 && p <= 13) ? rxw[13 - p] : 1'b1;
            if (p == pd_from) pdown_in = 1'b1;
            if (p == pd_to) pdown_in = 1'b0;
            wait_clk(3);
            if (pdown_in && p > pd_from)
                check(tx_oe == 1'b0, "R9 oe low during power-down", tx_oe, 0);
            @(negedge clk);
            bclk_in = 1'b0;
            wait_clk(3);
        end
        if (had_pd) muted_left = 2;
        check(valid_cnt == 1, "R8 one strobe per frame", valid_cnt, 1);
        check(got_word == rxw, "R7 received word", got_word, rxw);
        check(long_sync == (sync_bits >= 2), "R1 R2 pulse classification", long_sync, sync_bits >= 2);
        if (!had_pd) begin
            exp_oe = muted ? 0 : ((used_long != 0 && sync_bits > 13) ? (sync_bits - 1) * 8 : 100);
            check(oe_cyc == exp_oe, "R3 R5 R6 R9 enable window", oe_cyc, exp_oe);
            if (!muted)
                check(first_bit == txw[12], "R4 MSB first", first_bit, txw[12]);
        end
        exp_long = (sync_bits >= 2);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_oe == 1'b0, "R10 reset oe", tx_oe, 0);
        check(rx_valid == 1'b0, "R10 reset valid", rx_valid, 0);
        check(long_sync == 1'b0, "R10 reset mode", long_sync, 0);
        model_on = 1;
        wait_clk(4);
        run_frame(16, 13'h1ABC, 13'h0F0F, -1, -1); // R3 default short
        run_frame(16, 13'h0001, 13'h1555, -1, -1); // R6 hold until sync low
        run_frame(1,  13'h1000, 13'h0AAA, -1, -1); // R6 long, sync ends early
        run_frame(16, 13'h1FFF, 13'h1234, -1, -1); // R5 short after short pulse
        run_frame(3,  13'h0765, 13'h0001, -1, -1);
        run_frame(2,  13'h0A5A, 13'h1000, -1, -1);
        run_frame(1,  13'h15A5, 13'h1FFF, -1, -1);
        run_frame(5,  13'h0333, 13'h0C3C, 4, 9);   // R9 power-down mid frame
        run_frame(1,  13'h1111, 13'h0222, -1, -1); // R9 muted
        run_frame(14, 13'h0444, 13'h0888, -1, -1); // R9 muted
        run_frame(16, 13'h1248, 13'h0FED, -1, -1); // R9 drives again
        run_frame(1,  13'h0B0B, 13'h1C1C, -1, -1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule